// File: doc/BRIEF.md
# Dual-Core Boot Address Selector

After reset this block decides where each of two processor cores fetches its first instruction, and whether each core runs at all. It counts clock edges after reset is released and captures the boot-select pin on a fixed edge. That captured value chooses one of two programmed start addresses for each core.

Each chosen address is checked against a fixed map of memory regions. An address that lands in no region is replaced by a per-core fallback that depends on the pin. When the protection code is at its locked level, a core may start only from flash or from the system bootloader. Any other start address is forced to that core's flash entry point.

The results are registered once and then held until the next reset. Each core gets a start address, a release level and a master flag. The block has no streaming traffic: every port is a plain control or status pin. There is no valid/ready handshake and no back-pressure.

Top module: `bootsel_dual`

## Requirements
- R1: The boot pin is captured on the 4th rising clock edge after `rst_n` goes high. Pin changes on any later edge have no effect on the outputs until the next reset.
- R2: During reset and up to and including the 4th edge, all outputs are 0. On the 5th edge all outputs take their final values. The programmed addresses, enables and protection code are sampled on that edge only, and the outputs then stay unchanged until reset.
- R3: With a captured pin of 0 each core uses its `*_0` programmed address, and with a pin of 1 its `*_1` address, whenever that address is accepted by R4/R7.
- R4: The mapped regions are as follows:
  - ITCM: 0x0000_0000–0x0000_FFFF
  - flash: 0x0800_0000–0x081F_FFFF
  - SRAM aliases: 0x1000_0000–0x1001_FFFF, 0x1002_0000–0x1003_FFFF, 0x1004_0000–0x1004_7FFF
  - bootloader: 0x1FF0_0000–0x1FF1_FFFF
  - DTCM: 0x2000_0000–0x2001_FFFF
  - AXI SRAM: 0x2400_0000–0x2407_FFFF
  - SRAM1–3: 0x3000_0000–0x3001_FFFF, 0x3002_0000–0x3003_FFFF, 0x3004_0000–0x3004_7FFF
  - SRAM4: 0x3800_0000–0x3800_FFFF

  Everything else, including all addresses above 0x3FFF_FFFF, is unmapped.
- R5: If core A's selected address is unmapped and protection is not locked, core A starts at 0x0800_0000 for pin 0 and at 0x1FF0_0000 for pin 1.
- R6: If core B's selected address is unmapped and protection is not locked, core B starts at 0x0810_0000 for pin 0 and at 0x1000_0000 for pin 1.
- R7: With `prot_lvl` = 2'b10 (locked), a selected address in flash or the bootloader is kept. Any other address, whether RAM or unmapped, becomes 0x0800_0000 for core A and 0x0810_0000 for core B, whatever the pin.
- R8: The codes 2'b00, 2'b01 and 2'b11 apply only the region check of R4–R6, so valid RAM addresses are kept.
- R9: `release_b` equals `en_b`. `release_a` is 1 when `en_a` is 1 or when both enables are 0, so that at least one core always runs.
- R10: Exactly one master flag is set once the outputs are valid. `master_a` is set when A is enabled, or when neither core is enabled. `master_b` is set only when B alone is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin | input | 1 | Boot-select pin |
| en_a | input | 1 | Core A boot enable |
| en_b | input | 1 | Core B boot enable |
| prog_a0 | input | 32 | Core A start address for pin 0 |
| prog_a1 | input | 32 | Core A start address for pin 1 |
| prog_b0 | input | 32 | Core B start address for pin 0 |
| prog_b1 | input | 32 | Core B start address for pin 1 |
| prot_lvl | input | 2 | Protection code, 2'b10 = locked |
| boot_addr_a | output | 32 | Core A resolved start address |
| boot_addr_b | output | 32 | Core B resolved start address |
| release_a | output | 1 | Core A released (held high) |
| release_b | output | 1 | Core B released (held high) |
| master_a | output | 1 | Core A performs system initialisation |
| master_b | output | 1 | Core B performs system initialisation |

## Verification
Two cases can fall in the same cycle.

The first is the locked-protection override and the unmapped-address fallback. With the pin at 1, an unmapped address under lock could take either the pin-1 fallback or the lock fallback. The bench provokes this with an address of 0xFFFF_0000 for core A under lock. It accepts only 0x0800_0000, not 0x1FF0_0000.

The second is the pin capture and a pin change near the capture edge. The bench flips the pin just after the 4th edge and, in a separate case, two edges before it. It then checks that only the earlier flip shows in the selected addresses.

// File: rtl/bootsel_pkg.sv
`timescale 1ns/1ps
package bootsel_pkg;

  typedef enum logic [1:0] {
    RG_NONE    = 2'd0,
    RG_FLASH   = 2'd1,
    RG_SYSBOOT = 2'd2,
    RG_RAM     = 2'd3
  } region_e;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] last;
    region_e     kind;
  } region_t;

  localparam int          NUM_CORES   = 2;
  localparam int          NUM_REGIONS = 12;
  localparam int          LATCH_EDGE  = 4;
  localparam logic [31:0] ADDR_CEIL   = 32'h3FFF_FFFF;
  localparam logic [1:0]  PROT_LOCK   = 2'b10;

  localparam region_t REGION_MAP [NUM_REGIONS] = '{
    '{32'h0800_0000, 32'h081F_FFFF, RG_FLASH},
    '{32'h1FF0_0000, 32'h1FF1_FFFF, RG_SYSBOOT},
    '{32'h0000_0000, 32'h0000_FFFF, RG_RAM},
    '{32'h2000_0000, 32'h2001_FFFF, RG_RAM},
    '{32'h2400_0000, 32'h2407_FFFF, RG_RAM},
    '{32'h3000_0000, 32'h3001_FFFF, RG_RAM},
    '{32'h3002_0000, 32'h3003_FFFF, RG_RAM},
    '{32'h3004_0000, 32'h3004_7FFF, RG_RAM},
    '{32'h1000_0000, 32'h1001_FFFF, RG_RAM},
    '{32'h1002_0000, 32'h1003_FFFF, RG_RAM},
    '{32'h1004_0000, 32'h1004_7FFF, RG_RAM},
    '{32'h3800_0000, 32'h3800_FFFF, RG_RAM}
  };

  // index 0 = core A, index 1 = core B
  localparam logic [31:0] FALLBACK_PIN0 [NUM_CORES] = '{32'h0800_0000, 32'h0810_0000};
  localparam logic [31:0] FALLBACK_PIN1 [NUM_CORES] = '{32'h1FF0_0000, 32'h1000_0000};
  localparam logic [31:0] FALLBACK_LOCK [NUM_CORES] = '{32'h0800_0000, 32'h0810_0000};

endpackage

// File: rtl/bootsel_pin_latch.sv
`timescale 1ns/1ps
module bootsel_pin_latch #(
  parameter int EDGE_NUM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_q,
  output logic latched
);
  localparam int CW = $clog2(EDGE_NUM + 1);

  logic [CW-1:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      pin_q    <= 1'b0;
      latched  <= 1'b0;
    end else if (!latched) begin
      edge_cnt <= edge_cnt + 1'b1;
      if (edge_cnt == CW'(EDGE_NUM - 1)) begin
        latched <= 1'b1;
        pin_q   <= pin;
      end
    end
  end

  // R1: once captured, the pin copy never moves until reset
  p_pin_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> (latched && $stable(pin_q)));

endmodule

// File: rtl/bootsel_region_chk.sv
`timescale 1ns/1ps
module bootsel_region_chk
  import bootsel_pkg::*;
(
  input  logic [31:0] addr,
  output region_e     kind
);
  logic [NUM_REGIONS-1:0] hit;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_hit
    // offset compare avoids a constant-bound comparison for base 0
    assign hit[i] = (addr - REGION_MAP[i].base) <= (REGION_MAP[i].last - REGION_MAP[i].base);
  end

  always_comb begin
    kind = RG_NONE;
    if (addr <= ADDR_CEIL) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (hit[i]) kind = REGION_MAP[i].kind;
      end
    end
  end

endmodule

// File: rtl/bootsel_core_resolve.sv
`timescale 1ns/1ps
module bootsel_core_resolve
  import bootsel_pkg::*;
#(
  parameter logic [31:0] FB_PIN0 = 32'h0800_0000,
  parameter logic [31:0] FB_PIN1 = 32'h1FF0_0000,
  parameter logic [31:0] FB_LOCK = 32'h0800_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin,
  input  logic [1:0]  prot,
  input  logic [31:0] addr0,
  input  logic [31:0] addr1,
  output logic [31:0] addr_out
);
  logic [31:0] sel_addr;
  region_e     sel_kind;
  region_e     out_kind;
  logic        locked;
  logic        boot_ok;

  assign sel_addr = pin ? addr1 : addr0;
  assign locked   = (prot == PROT_LOCK);
  assign boot_ok  = (sel_kind == RG_FLASH) || (sel_kind == RG_SYSBOOT);

  bootsel_region_chk u_sel_chk (.addr(sel_addr), .kind(sel_kind));

  always_comb begin
    if (locked)
      addr_out = boot_ok ? sel_addr : FB_LOCK;
    else if (sel_kind != RG_NONE)
      addr_out = sel_addr;
    else
      addr_out = pin ? FB_PIN1 : FB_PIN0;
  end

  // independent classification of the result, used only for checking
  bootsel_region_chk u_out_chk (.addr(addr_out), .kind(out_kind));

  // R5: whatever is selected, the start address lands in a mapped region
  p_result_mapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_kind != RG_NONE);

  // R7: under lock only flash or bootloader starts are produced
  p_lock_boot_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot == PROT_LOCK) |-> (out_kind == RG_FLASH || out_kind == RG_SYSBOOT));

endmodule

// File: rtl/bootsel_dual.sv
`timescale 1ns/1ps
module bootsel_dual
  import bootsel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_pin,
  input  logic        en_a,
  input  logic        en_b,
  input  logic [31:0] prog_a0,
  input  logic [31:0] prog_a1,
  input  logic [31:0] prog_b0,
  input  logic [31:0] prog_b1,
  input  logic [1:0]  prot_lvl,
  output logic [31:0] boot_addr_a,
  output logic [31:0] boot_addr_b,
  output logic        release_a,
  output logic        release_b,
  output logic        master_a,
  output logic        master_b
);
  logic        pin_q;
  logic        latched;
  logic        out_valid;
  logic [31:0] prog0 [NUM_CORES];
  logic [31:0] prog1 [NUM_CORES];
  logic [31:0] res   [NUM_CORES];

  assign prog0[0] = prog_a0;
  assign prog1[0] = prog_a1;
  assign prog0[1] = prog_b0;
  assign prog1[1] = prog_b1;

  bootsel_pin_latch #(.EDGE_NUM(LATCH_EDGE)) u_latch (
    .clk(clk), .rst_n(rst_n), .pin(boot_pin), .pin_q(pin_q), .latched(latched)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    bootsel_core_resolve #(
      .FB_PIN0(FALLBACK_PIN0[c]),
      .FB_PIN1(FALLBACK_PIN1[c]),
      .FB_LOCK(FALLBACK_LOCK[c])
    ) u_res (
      .clk(clk), .rst_n(rst_n), .pin(pin_q), .prot(prot_lvl),
      .addr0(prog0[c]), .addr1(prog1[c]), .addr_out(res[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      boot_addr_a <= '0;
      boot_addr_b <= '0;
      release_a   <= 1'b0;
      release_b   <= 1'b0;
      master_a    <= 1'b0;
      master_b    <= 1'b0;
    end else if (latched && !out_valid) begin
      out_valid   <= 1'b1;
      boot_addr_a <= res[0];
      boot_addr_b <= res[1];
      release_a   <= en_a | ~en_b;
      release_b   <= en_b;
      master_a    <= en_a | ~en_b;
      master_b    <= ~en_a & en_b;
    end
  end

  // R2: outputs appear only on the edge following pin capture
  p_valid_after_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(latched));

  // R2: nothing is released before the outputs become valid
  p_quiet_before_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!release_a && !release_b && !master_a && !master_b
                    && boot_addr_a == 32'h0 && boot_addr_b == 32'h0));

  // R2: once valid, every output holds until reset
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (out_valid && $stable(boot_addr_a) && $stable(boot_addr_b)
                   && $stable(release_a) && $stable(release_b)
                   && $stable(master_a) && $stable(master_b)));

  // R9: at least one core runs
  p_some_core_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (release_a || release_b));

  // R10: exactly one master, and the master is a released core
  p_one_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({master_a, master_b}) == 1
                   && (!master_a || release_a) && (!master_b || release_b)));

endmodule

// File: tb/tb_bootsel_dual.sv
`timescale 1ns/1ps
module tb_bootsel_dual;

  typedef struct packed {
    logic [31:0] addr_a;
    logic [31:0] addr_b;
    logic        rel_a;
    logic        rel_b;
    logic        mst_a;
    logic        mst_b;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_pin = 1'b0;
  logic        en_a = 1'b0, en_b = 1'b0;
  logic [31:0] prog_a0 = '0, prog_a1 = '0, prog_b0 = '0, prog_b1 = '0;
  logic [1:0]  prot_lvl = 2'b00;
  logic [31:0] boot_addr_a, boot_addr_b;
  logic        release_a, release_b, master_a, master_b;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   ecnt  = 0;
  exp_t exp_q [$];
  exp_t hold;

  always #5 clk = ~clk;

  bootsel_dual dut (
    .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .en_a(en_a), .en_b(en_b),
    .prog_a0(prog_a0), .prog_a1(prog_a1), .prog_b0(prog_b0), .prog_b1(prog_b1),
    .prot_lvl(prot_lvl), .boot_addr_a(boot_addr_a), .boot_addr_b(boot_addr_b),
    .release_a(release_a), .release_b(release_b), .master_a(master_a), .master_b(master_b)
  );

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else if (ecnt < 20) ecnt <= ecnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 = unmapped, 1 = flash or bootloader, 2 = RAM (R4)
  function automatic int map_kind(input logic [31:0] a);
    if (a >= 32'h0800_0000 && a <= 32'h081F_FFFF) return 1;
    if (a >= 32'h1FF0_0000 && a <= 32'h1FF1_FFFF) return 1;
    if (a <= 32'h0000_FFFF) return 2;
    if (a >= 32'h1000_0000 && a <= 32'h1004_7FFF) return 2;
    if (a >= 32'h2000_0000 && a <= 32'h2001_FFFF) return 2;
    if (a >= 32'h2400_0000 && a <= 32'h2407_FFFF) return 2;
    if (a >= 32'h3000_0000 && a <= 32'h3004_7FFF) return 2;
    if (a >= 32'h3800_0000 && a <= 32'h3800_FFFF) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] model(input bit core_b, input logic pin,
                                        input logic [31:0] a0, input logic [31:0] a1,
                                        input logic [1:0] pr);
    logic [31:0] s;
    int k;
    s = pin ? a1 : a0;
    k = map_kind(s);
    if (pr == 2'b10) return (k == 1) ? s : (core_b ? 32'h0810_0000 : 32'h0800_0000);
    if (k != 0) return s;
    if (core_b) return pin ? 32'h1000_0000 : 32'h0810_0000;
    return pin ? 32'h1FF0_0000 : 32'h0800_0000;
  endfunction

  // driver: pushes expected result, then runs one reset-to-release sequence
  task automatic run_case(input logic pin_i, input int flip_at, input logic ea, input logic eb,
                          input logic [31:0] a0, input logic [31:0] a1,
                          input logic [31:0] b0, input logic [31:0] b1, input logic [1:0] pr);
    exp_t e;
    logic pe;
    rst_n = 1'b0;
    boot_pin = pin_i; en_a = ea; en_b = eb;
    prog_a0 = a0; prog_a1 = a1; prog_b0 = b0; prog_b1 = b1; prot_lvl = pr;
    repeat (2) @(negedge clk);
    check("R2 reset addr_a", boot_addr_a, 32'h0);
    check("R2 reset flags", {28'h0, release_a, release_b, master_a, master_b}, 32'h0);
    pe = (flip_at == 2) ? ~pin_i : pin_i;
    e.addr_a = model(1'b0, pe, a0, a1, pr);
    e.addr_b = model(1'b1, pe, b0, b1, pr);
    e.rel_a  = ea | ~eb;
    e.rel_b  = eb;
    e.mst_a  = ea | ~eb;
    e.mst_b  = ~ea & eb;
    exp_q.push_back(e);
    rst_n = 1'b1;
    while (ecnt < 10) begin
      @(negedge clk);
      if (ecnt == flip_at) boot_pin = ~boot_pin;   // R1 early/late flip
      if (ecnt == 6) begin                          // R2: late input changes ignored
        boot_pin = ~boot_pin; en_a = ~en_a; en_b = ~en_b; prot_lvl = ~prot_lvl;
        prog_a0 = ~prog_a0; prog_a1 = ~prog_a1; prog_b0 = ~prog_b0; prog_b1 = ~prog_b1;
      end
    end
  endtask

  // monitor: compares outputs at fixed points after reset release
  always @(negedge clk) begin
    if (rst_n) begin
      if (ecnt == 4) begin
        check("R2 quiet at capture edge", {boot_addr_a[3:0], boot_addr_b[3:0], release_a, release_b, master_a, master_b}, 32'h0);
      end else if (ecnt == 5) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2 output without expected item actual=%h expected=none", boot_addr_a);
        end else begin
          hold = exp_q.pop_front();
          check("R3/R5/R7 addr_a", boot_addr_a, hold.addr_a);
          check("R3/R6/R8 addr_b", boot_addr_b, hold.addr_b);
          check("R9 release_a", {31'h0, release_a}, {31'h0, hold.rel_a});
          check("R9 release_b", {31'h0, release_b}, {31'h0, hold.rel_b});
          check("R10 master", {30'h0, master_a, master_b}, {30'h0, hold.mst_a, hold.mst_b});
        end
      end else if (ecnt == 9) begin
        check("R2 hold addr_a", boot_addr_a, hold.addr_a);
        check("R2 hold addr_b", boot_addr_b, hold.addr_b);
        check("R2 hold flags", {28'h0, release_a, release_b, master_a, master_b},
              {28'h0, hold.rel_a, hold.rel_b, hold.mst_a, hold.mst_b});
      end
    end
  end

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R3 R4: pin 0, flash and DTCM kept, both enabled -> A master
    run_case(1'b0, 0, 1'b1, 1'b1, 32'h0800_1000, 32'h2400_0000, 32'h2000_0100, 32'h0, 2'b00);
    // R3 R4 R9 R10: pin 1, AXI SRAM and SRAM3 top, only B enabled
    run_case(1'b1, 0, 1'b0, 1'b1, 32'h0, 32'h2400_0000, 32'h0, 32'h3004_7FFC, 2'b00);
    // R5 R6 R9: pin 0, gap after ITCM and above ceiling, none enabled -> A runs
    run_case(1'b0, 0, 1'b0, 1'b0, 32'h0001_0000, 32'h0, 32'h4000_0000, 32'h0, 2'b00);
    // R5 R6 R8: pin 1, gaps under code 11
    run_case(1'b1, 0, 1'b1, 1'b0, 32'h0, 32'h3004_8000, 32'h0, 32'h1FF2_0000, 2'b11);
    // R7: lock keeps bootloader, forces RAM to flash
    run_case(1'b1, 0, 1'b1, 1'b1, 32'h0, 32'h1FF1_FFF0, 32'h0, 32'h3800_0000, 2'b10);
    // R7: lock + unmapped with pin 1 -> lock fallback wins; flash kept for B
    run_case(1'b1, 0, 1'b1, 1'b1, 32'h0, 32'hFFFF_0000, 32'h0, 32'h081F_FFFC, 2'b10);
    // R1: flip after capture edge is ignored
    run_case(1'b0, 4, 1'b1, 1'b1, 32'h0800_0040, 32'h1FF0_0040, 32'h0810_0040, 32'h1000_0040, 2'b00);
    // R1: flip before capture edge is taken
    run_case(1'b1, 2, 1'b1, 1'b1, 32'h0800_0080, 32'h1FF0_0080, 32'h0810_0080, 32'h1000_0080, 2'b01);
    // R8: aliases and AXI top under code 01
    run_case(1'b0, 0, 1'b1, 1'b1, 32'h1002_0000, 32'h0, 32'h2407_FFFC, 32'h0, 2'b01);
    // R7: lock with ITCM start -> forced, pin 0
    run_case(1'b0, 0, 1'b0, 1'b1, 32'h0000_0100, 32'h0, 32'h0800_0000, 32'h0, 2'b10);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule